// File: doc/BRIEF.md
# DDR2 Burst Interrupt and Precharge Timing Guard

This block watches the command stream that a DDR2 controller's scheduler places on the DRAM command bus. For every issued read, write, read with auto-precharge, write with auto-precharge or precharge, it decides whether the command cuts into an open data burst in a way the DRAM does not allow. It also judges whether a precharge reaches its bank too early. When either check fails it raises a violation flag with a reason code one clock later. The offending command is still recorded, so later judgements follow the command stream as it was really issued.

The block also keeps one countdown per bank and drives a per-bank precharge-ready output. A read sets its bank's earliest precharge to additive latency plus half the programmed burst length. A write sets it to write latency plus half the burst length plus write recovery. Both are always measured against the programmed burst length, even when a later command cuts the burst short. The mode settings (burst length select, additive latency, write latency, write recovery) are copied into the block only while no burst is open and no command is being issued.

Top module: `ddr2_burst_guard`

## Requirements
- R1: After reset the violation flag is low, the reason code is 0 and every bank's precharge-ready bit is high.
- R2: With burst length 4 selected (mode select 0), a read or write issued one clock after the previous read or write is flagged with reason 1. A read or write two or more clocks later is not treated as inside the burst.
- R3: With burst length 8 (mode select 1), a write issued 1 to 3 clocks after a read, or a read issued 1 to 3 clocks after a write, is flagged with reason 2.
- R4: A precharge issued while a burst is open (1 to BL/2-1 clocks after the last read or write) is flagged with reason 3, whatever its bank.
- R5: With burst length 8, a read following a read, or a write following a write, is legal only at exactly two clocks. It may target any bank. At one or three clocks it is flagged with reason 4.
- R6: A command that lands inside a burst opened by a read or write with auto-precharge is flagged with reason 5. A read or write with auto-precharge may itself interrupt a plain burst of its own type at the two-clock point.
- R7: After a read to bank b in cycle t, precharge-ready for bank b is low from t+1 and rises in cycle t+AL+BL/2. If a second read to another bank interrupts the burst, the first bank's timing is unchanged.
- R8: After a write to bank b in cycle t, precharge-ready for bank b rises in cycle t+WL+BL/2+tWR. A bank's ready time is never moved earlier by a later command.
- R9: A precharge issued outside any burst to a bank whose precharge-ready bit is low is flagged with reason 6.
- R10: The flag and reason are registered and show in the cycle after the command. An illegal read or write still becomes the new reference for later spacing checks.
- R11: Mode inputs are captured only in a cycle with no open burst and no command. Changes made while a burst is open have no effect until such a cycle.
- R12: Command kind encodings are read 0, read with auto-precharge 1, write 2, write with auto-precharge 3, precharge 4. Kinds 5 to 7, and cycles with the valid input low, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 3 | Command kind, encoded as in R12 |
| cmd_bank | input | BANK_W | Target bank of the command |
| mode_bl8 | input | 1 | Burst length select: 0 for 4, 1 for 8 |
| mode_al | input | MODE_W | Additive latency in clocks |
| mode_wl | input | MODE_W | Write latency in clocks |
| mode_twr | input | MODE_W | Write recovery in clocks |
| viol_flag | output | 1 | Previous cycle's command broke a rule |
| viol_code | output | 3 | Reason for the violation, 0 when none |
| pre_ok | output | NUM_BANKS | Per-bank precharge-ready |

## Verification
The bench builds the block with four banks instead of the default eight. With fewer banks, random commands often hit a bank whose countdown is still running, so early precharges and the later-command-never-shortens rule come up often. Latencies are kept small (AL 0 to 3, WL 1 to 5, write recovery 1 to 4) and the timer width is left at its default. With these settings, countdowns expire within a few dozen clocks, and the random stream often crosses ready edges exactly. Mode values change at random while bursts are open, so the idle-only capture is exercised across both burst lengths.

// File: rtl/ddr2_guard_pkg.sv
// Shared encodings for the DDR2 burst guard.
// Assumes commands arrive as a 3-bit kind; kinds above CMD_PRE are ignored.
package ddr2_guard_pkg;

    typedef enum logic [2:0] {
        CMD_RD  = 3'd0,
        CMD_RDA = 3'd1,
        CMD_WR  = 3'd2,
        CMD_WRA = 3'd3,
        CMD_PRE = 3'd4
    } cmd_kind_e;

    typedef enum logic [2:0] {
        WHY_NONE         = 3'd0,
        WHY_BL4          = 3'd1,
        WHY_CROSS        = 3'd2,
        WHY_PRE_IN_BURST = 3'd3,
        WHY_SPACING      = 3'd4,
        WHY_AP_OPEN      = 3'd5,
        WHY_PRE_EARLY    = 3'd6
    } why_e;

endpackage

// File: rtl/ddr2_guard_mode.sv
// Holds the mode settings used by the guard.
// Copies the live mode inputs only in idle cycles (no open burst, no command),
// so that a burst is always judged with the settings it started under.
module ddr2_guard_mode #(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic              bl8_in,
    input  logic [MODE_W-1:0] al_in,
    input  logic [MODE_W-1:0] wl_in,
    input  logic [MODE_W-1:0] twr_in,
    output logic              bl8,
    output logic [MODE_W-1:0] al,
    output logic [MODE_W-1:0] wl,
    output logic [MODE_W-1:0] twr
);

    // Capture the mode inputs when the command bus is quiet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl8 <= 1'b0;
            al  <= '0;
            wl  <= '0;
            twr <= '0;
        end else if (idle) begin
            bl8 <= bl8_in;
            al  <= al_in;
            wl  <= wl_in;
            twr <= twr_in;
        end
    end

    assert_mode_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable({bl8, al, wl, twr}));

endmodule

// File: rtl/ddr2_guard_burst.sv
// Burst-interrupt judge.
// Tracks the age of the last read or write together with its type and
// auto-precharge bit, and classifies the current command against the open burst.
// Assumes the burst window is 1..BL/2-1 clocks after the last read/write.
// Early-precharge checks against bank timers are done by the parent.
module ddr2_guard_burst
    import ddr2_guard_pkg::*;
#(
    parameter int AGE_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_kind,
    input  logic       bl8,
    output logic       in_burst,
    output why_e       reason
);

    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
    localparam logic [AGE_W-1:0] HALF4   = AGE_W'(2);
    localparam logic [AGE_W-1:0] HALF8   = AGE_W'(4);
    localparam logic [AGE_W-1:0] ALLOWED = AGE_W'(2);

    logic [AGE_W-1:0] age_q;
    logic             prev_wr_q;
    logic             prev_ap_q;
    logic [AGE_W-1:0] half;
    logic             rw_cmd;
    logic             pre_cmd;

    // Decode the command and the programmed half burst.
    always_comb begin
        rw_cmd   = cmd_valid && !cmd_kind[2];
        pre_cmd  = cmd_valid && (cmd_kind == CMD_PRE);
        half     = bl8 ? HALF8 : HALF4;
        in_burst = (age_q != '0) && (age_q < half);
    end

    // Classify the command against the open burst, highest priority first.
    always_comb begin
        reason = WHY_NONE;
        if (in_burst) begin
            if (pre_cmd)                         reason = WHY_PRE_IN_BURST;
            else if (rw_cmd) begin
                if (!bl8)                        reason = WHY_BL4;
                else if (cmd_kind[1] != prev_wr_q) reason = WHY_CROSS;
                else if (prev_ap_q)              reason = WHY_AP_OPEN;
                else if (age_q != ALLOWED)       reason = WHY_SPACING;
            end
        end
    end

    // Every read or write, legal or not, becomes the new burst reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q     <= AGE_MAX;
            prev_wr_q <= 1'b0;
            prev_ap_q <= 1'b0;
        end else if (rw_cmd) begin
            age_q     <= AGE_W'(1);
            prev_wr_q <= cmd_kind[1];
            prev_ap_q <= cmd_kind[0];
        end else if (age_q != AGE_MAX) begin
            age_q     <= age_q + AGE_W'(1);
        end
    end

    assert_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rw_cmd && $past(cmd_valid && !cmd_kind[2])) |-> (reason != WHY_NONE));

    assert_pre_after_rw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cmd && $past(cmd_valid && !cmd_kind[2])) |-> (reason == WHY_PRE_IN_BURST));

endmodule

// File: rtl/ddr2_guard_bank_timer.sv
// Earliest-precharge countdown for one bank.
// A load at cycle t with delay D makes ready rise at cycle t+D. A load never
// shortens a countdown that is still running. Assumes D >= 1.
module ddr2_guard_bank_timer #(
    parameter int TIMER_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TIMER_W-1:0] delay,
    output logic               ready
);

    logic [TIMER_W-1:0] cnt_q;
    logic [TIMER_W-1:0] dec;
    logic [TIMER_W-1:0] tgt;

    // Saturating next count and the target implied by the new command.
    always_comb begin
        dec   = (cnt_q == '0) ? '0 : cnt_q - TIMER_W'(1);
        tgt   = delay - TIMER_W'(1);
        ready = (cnt_q == '0);
    end

    // Count down, taking the later of the running and the new deadline.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= (tgt > dec) ? tgt : dec;
        else           cnt_q <= dec;
    end

    assert_load_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ready);

    assert_fall_needs_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(load));

endmodule

// File: rtl/ddr2_burst_guard.sv
// DDR2 burst interrupt and precharge timing guard (top).
// Watches issued commands and flags illegal burst interrupts and early
// precharges one cycle after the command. Drives per-bank precharge-ready
// measured from the nominal burst end. Assumes at most one command per cycle.
module ddr2_burst_guard
    import ddr2_guard_pkg::*;
#(
    parameter  int NUM_BANKS = 8,
    parameter  int MODE_W    = 4,
    parameter  int TIMER_W   = 6,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_kind,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic                 mode_bl8,
    input  logic [MODE_W-1:0]    mode_al,
    input  logic [MODE_W-1:0]    mode_wl,
    input  logic [MODE_W-1:0]    mode_twr,
    output logic                 viol_flag,
    output logic [2:0]           viol_code,
    output logic [NUM_BANKS-1:0] pre_ok
);

    localparam int AGE_W = 3;

    logic              bl8;
    logic [MODE_W-1:0] al, wl, twr;
    logic              in_burst;
    why_e              burst_why;
    why_e              why;
    logic              live_cmd;
    logic              rw_cmd;
    logic              pre_cmd;
    logic              idle;
    logic [TIMER_W-1:0] half_t;
    logic [TIMER_W-1:0] rd_delay;
    logic [TIMER_W-1:0] wr_delay;

    // Command decode and deadlines implied by the captured mode.
    always_comb begin
        live_cmd = cmd_valid && (cmd_kind <= CMD_PRE);
        rw_cmd   = cmd_valid && !cmd_kind[2];
        pre_cmd  = cmd_valid && (cmd_kind == CMD_PRE);
        idle     = !in_burst && !live_cmd;
        half_t   = bl8 ? TIMER_W'(4) : TIMER_W'(2);
        rd_delay = TIMER_W'(al) + half_t;
        wr_delay = TIMER_W'(wl) + half_t + TIMER_W'(twr);
    end

    ddr2_guard_mode #(.MODE_W(MODE_W)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle   (idle),
        .bl8_in (mode_bl8),
        .al_in  (mode_al),
        .wl_in  (mode_wl),
        .twr_in (mode_twr),
        .bl8    (bl8),
        .al     (al),
        .wl     (wl),
        .twr    (twr)
    );

    ddr2_guard_burst #(.AGE_W(AGE_W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .bl8       (bl8),
        .in_burst  (in_burst),
        .reason    (burst_why)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ddr2_guard_bank_timer #(.TIMER_W(TIMER_W)) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (rw_cmd && (cmd_bank == BANK_W'(b))),
            .delay (cmd_kind[1] ? wr_delay : rd_delay),
            .ready (pre_ok[b])
        );
    end

    // Merge burst verdict with the early-precharge verdict.
    always_comb begin
        why = burst_why;
        if (why == WHY_NONE && pre_cmd && !pre_ok[cmd_bank])
            why = WHY_PRE_EARLY;
    end

    // Register the verdict for the cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_flag <= 1'b0;
            viol_code <= 3'd0;
        end else begin
            viol_flag <= (why != WHY_NONE);
            viol_code <= why;
        end
    end

    assert_flag_needs_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |-> $past(cmd_valid && (cmd_kind <= CMD_PRE)));

    assert_early_pre_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_cmd && !in_burst && !pre_ok[cmd_bank]) |=> (viol_code == WHY_PRE_EARLY));

    assert_flag_code_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag == (viol_code != 3'd0));

endmodule

// File: tb/ddr2_burst_guard_bench.sv
// Bench for ddr2_burst_guard: directed corner cases plus seeded random
// commands, checked against a behavioural model written from the requirements.
module ddr2_burst_guard_bench;

    localparam int NB  = 4;
    localparam int BW  = 2;
    localparam int MW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_kind = 3'd0;
    logic [BW-1:0] cmd_bank = '0;
    logic          mode_bl8 = 1'b0;
    logic [MW-1:0] mode_al = '0, mode_wl = '0, mode_twr = '0;
    logic          viol_flag;
    logic [2:0]    viol_code;
    logic [NB-1:0] pre_ok;

    int checks = 0;
    int failures = 0;

    // model state
    bit m_bl8;
    int m_al, m_wl, m_twr;
    int m_age;
    bit m_prev_wr, m_prev_ap;
    int m_cnt[NB];

    always #10 clk = ~clk;

    ddr2_burst_guard #(.NUM_BANKS(NB), .MODE_W(MW)) u_ddr2_burst_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_bank(cmd_bank), .mode_bl8(mode_bl8), .mode_al(mode_al),
        .mode_wl(mode_wl), .mode_twr(mode_twr), .viol_flag(viol_flag),
        .viol_code(viol_code), .pre_ok(pre_ok)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int half_of(bit bl8);
        return bl8 ? 4 : 2;
    endfunction

    function automatic bit model_in_burst();
        return (m_age >= 1) && (m_age < half_of(m_bl8));
    endfunction

    // Expected reason code for a command against the model state (R2..R6, R9, R12).
    function automatic int model_code(bit v, int k, int b);
        bit rw = v && (k <= 3);
        bit pre = v && (k == 4);
        bit inb = model_in_burst();
        if (pre && inb) return 3;
        if (rw && inb) begin
            if (!m_bl8) return 1;
            if (((k >> 1) & 1) != int'(m_prev_wr)) return 2;
            if (m_prev_ap) return 5;
            if (m_age != 2) return 4;
            return 0;
        end
        if (pre && m_cnt[b] != 0) return 6;
        return 0;
    endfunction

    task automatic model_reset();
        m_bl8 = 0; m_al = 0; m_wl = 0; m_twr = 0;
        m_age = 100; m_prev_wr = 0; m_prev_ap = 0;
        for (int i = 0; i < NB; i++) m_cnt[i] = 0;
    endtask

    // Advance the model by one clock edge (R7, R8, R10, R11).
    task automatic model_update(bit v, int k, int b);
        bit rw = v && (k <= 3);
        bit idle = !model_in_burst() && !(v && k <= 4);
        int d;
        for (int i = 0; i < NB; i++) begin
            int dec = (m_cnt[i] > 0) ? m_cnt[i] - 1 : 0;
            if (rw && i == b) begin
                d = (k >= 2) ? m_wl + half_of(m_bl8) + m_twr : m_al + half_of(m_bl8);
                m_cnt[i] = (d - 1 > dec) ? d - 1 : dec;
            end else begin
                m_cnt[i] = dec;
            end
        end
        if (rw) begin
            m_age = 1; m_prev_wr = (k >= 2); m_prev_ap = k[0];
        end else if (m_age < 100) begin
            m_age++;
        end
        if (idle) begin
            m_bl8 = mode_bl8; m_al = mode_al; m_wl = mode_wl; m_twr = mode_twr;
        end
    endtask

    // One command cycle: drive, check pre_ok, clock, check verdict.
    task automatic step(bit v, int k, int b, string tag);
        int exp;
        @(negedge clk);
        cmd_valid = v; cmd_kind = 3'(k); cmd_bank = BW'(b);
        #1;
        for (int i = 0; i < NB; i++)
            chk({tag, " pre_ok R7/R8"}, int'(pre_ok[i]), int'(m_cnt[i] == 0));
        exp = model_code(v, k, b);
        @(posedge clk);
        #1;
        chk({tag, " code R10"}, int'(viol_code), exp);
        chk({tag, " flag R10"}, int'(viol_flag), int'(exp != 0));
        model_update(v, k, b);
    endtask

    task automatic idle_n(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, "idle");
    endtask

    task automatic set_mode(bit bl8, int al, int wl, int twr);
        mode_bl8 = bl8; mode_al = MW'(al); mode_wl = MW'(wl); mode_twr = MW'(twr);
    endtask

    initial begin
        #(20ns * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 flag", int'(viol_flag), 0);
        chk("R1 code", int'(viol_code), 0);
        chk("R1 pre_ok", int'(pre_ok), (1 << NB) - 1);

        set_mode(1, 1, 3, 3);
        idle_n(3);

        // R5/R7: legal cross-bank read interrupt; bank0 timing stays nominal.
        step(1, 0, 0, "R7 rd b0");
        step(0, 0, 0, "R7 gap");
        step(1, 0, 1, "R5 rd b1 at +2");
        chk("R5 legal interrupt", int'(viol_code), 0);
        step(0, 0, 0, "R7 wait");
        chk("R7 bank0 not yet", int'(pre_ok[0]), 0);
        step(0, 0, 0, "R7 wait");
        chk("R7 bank0 at AL+BL/2", int'(pre_ok[0]), 1);
        chk("R7 bank1 busy", int'(pre_ok[1]), 0);
        idle_n(2);
        chk("R7 bank1 ready", int'(pre_ok[1]), 1);
        idle_n(4);

        // R3: write inside a read burst.
        step(1, 0, 0, "R3 rd"); step(0, 0, 0, "R3 gap");
        step(1, 2, 0, "R3 wr");
        chk("R3 cross type", int'(viol_code), 2);
        idle_n(12);

        // R5/R10: wrong spacing, and the illegal write becomes the reference.
        step(1, 2, 2, "R5 wr"); step(1, 2, 2, "R5 wr +1");
        chk("R5 spacing one", int'(viol_code), 4);
        step(0, 0, 0, "R10 gap"); step(1, 2, 3, "R10 wr +2 of illegal");
        chk("R10 new reference", int'(viol_code), 0);
        idle_n(16);

        // R6: auto-precharge burst cannot be interrupted; AP may interrupt.
        step(1, 1, 1, "R6 rda"); step(0, 0, 0, "R6 gap");
        step(1, 0, 1, "R6 rd");
        chk("R6 ap burst", int'(viol_code), 5);
        idle_n(12);
        step(1, 0, 3, "R6 rd"); step(0, 0, 0, "R6 gap");
        step(1, 1, 2, "R6 rda interrupts");
        chk("R6 ap interrupter", int'(viol_code), 0);
        idle_n(12);

        // R4: precharge inside a write burst.
        step(1, 2, 0, "R4 wr"); step(0, 0, 0, "R4 gap");
        step(1, 4, 3, "R4 pre");
        chk("R4 pre in burst", int'(viol_code), 3);
        idle_n(16);

        // R9/R8: write to precharge = WL+BL/2+tWR = 10.
        step(1, 2, 1, "R8 wr");
        idle_n(8);
        step(1, 4, 1, "R9 pre at +9");
        chk("R9 early pre", int'(viol_code), 6);
        step(1, 4, 1, "R8 pre at +10");
        chk("R8 pre on time", int'(viol_code), 0);
        idle_n(4);

        // R11: change to BL4 while a burst is open has no effect.
        step(1, 0, 0, "R11 rd");
        set_mode(0, 1, 3, 3);
        step(0, 0, 0, "R11 gap");
        step(1, 0, 0, "R11 rd +2");
        step(0, 0, 0, "R11 gap"); step(0, 0, 0, "R11 gap");
        step(1, 0, 0, "R11 rd +3");
        chk("R11 still BL8", int'(viol_code), 4);
        idle_n(12);

        // R2: BL4 now captured.
        step(1, 0, 0, "R2 rd"); step(1, 0, 0, "R2 rd +1");
        chk("R2 bl4 interrupt", int'(viol_code), 1);
        step(0, 0, 0, "R2 gap"); step(1, 2, 0, "R2 wr +2");
        chk("R2 after window", int'(viol_code), 0);
        idle_n(12);

        // R12: ignored kinds and invalid cycles.
        step(1, 0, 2, "R12 rd"); step(1, 7, 2, "R12 kind7");
        chk("R12 kind7 ignored", int'(viol_code), 0);
        step(0, 4, 2, "R12 invalid pre");
        chk("R12 invalid ignored", int'(viol_code), 0);
        idle_n(12);

        // Seeded random traffic against the model.
        seed = $urandom(20240611);
        for (int n = 0; n < 4000; n++) begin
            bit v;
            int k, b;
            if ($urandom_range(9) == 0)
                set_mode(1'($urandom_range(1)), $urandom_range(3),
                         1 + $urandom_range(4), 1 + $urandom_range(3));
            v = ($urandom_range(99) < 45);
            k = $urandom_range(7);
            b = $urandom_range(NB - 1);
            step(v, k, b, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule